// File: doc/BRIEF.md
# Three-Channel Up/Down Interval Timer

This peripheral holds three independent 32-bit timers behind a byte-wide register bus. Each timer has a live counter, a reload word and two compare words. A timer counts on every system clock or only on cycles where a slow tick-enable pulse is high; that pulse stands in for a 32768 Hz source that has already been brought into the system clock domain. The count direction can be up or down. When the counter sits at zero, the next count event loads it with its reload word.

The three timers share one control word and one status word. Each timer owns an interleaved 3-bit group in both words, and the direction bits sit together above those groups. The status flags are sticky and are cleared by writing ones to them. A single interrupt line is high whenever any status flag is set. A mask word can be read and written but has no effect on the interrupt. A constant identification word completes the map.

Top module: `triple_interval_timer`

## Requirements
- R1: While `rstN` is low, every register reads zero and `irq` is low. This includes the counters, the reload and compare words, and the control, status and mask words.
- R2: Timer i (i = 0..2) has four 32-bit words at byte offset 0x10*i + 4*f. The field f is 0 for the counter, 1 for reload, 2 for compare A and 3 for compare B. Byte k of a word, at offset +k, holds bits 8k+7..8k, so the layout is little-endian. Each byte is written and read on its own.
- R3: Control bit 3i enables timer i. Bit 3i+1 selects the slow tick when 1 and the system clock when 0. Bit 9+i selects up-counting when 1 and down-counting when 0. An enabled, down-counting timer on the system clock decrements by one on every clock.
- R4: When bit 3i+1 is 1, the timer advances only on clocks where `slowTick` is high and holds on all other clocks.
- R5: An up-counting timer adds one per count event and wraps from 0xFFFFFFFF to 0.
- R6: When a count event finds the counter at 0, the counter loads the reload word instead of stepping. This applies in both directions.
- R7: When a count event moves the counter onto compare A, status bit 3i is set. When it moves the counter onto compare B, status bit 3i+1 is set.
- R8: A reload from zero sets status bit 3i+2, but only when control bit 3i+2 is 1.
- R9: The status word sits at offset 0x34 (bytes 0 and 1). Writing a 1 to a bit clears it. A flag that hardware sets in the same clock as a clearing write stays set.
- R10: `irq` is the OR of the twelve status bits. The 12-bit word at 0x38/0x39 reads back what was written and never changes `irq`.
- R11: Offsets 0x3C..0x3F read 0x00010801, least significant byte first. The control word lives at 0x30/0x31 and its upper four bits read 0. Bytes 0x32, 0x33, 0x36, 0x37, 0x3A, 0x3B and 0x3C..0x3F ignore writes, and the unused bytes among them read 0.
- R12: A byte write to a counter takes priority over a count event in the same clock. The bytes that are not written keep their old value. A disabled timer holds its counter.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Asynchronous active-low reset |
| busAddr | input | 6 | Byte offset of the access |
| busWrEn | input | 1 | Byte write strobe |
| busWrData | input | 8 | Write data byte |
| busRdData | output | 8 | Combinational read data for `busAddr` |
| slowTick | input | 1 | One-clock tick enable for the slow source |
| irq | output | 1 | Combined interrupt, OR of all status flags |

## Verification
A wrong counter step or a missed reload shows up on the counter bytes at the very next count event. On the system clock that is one clock later; on the slow source it is the next tick. A flag that is wrongly set or left uncleared reaches `irq` in the same clock as the status register, so the bench reads the status bytes and `irq` right after each event. Gating mistakes need a counter that passes through zero with the zero-interrupt enable off. Priority mistakes need a clearing write, or a counter write, that lands in exactly the clock of a hardware event. The directed tests place those writes on that clock.

// File: rtl/tmr_pkg.sv
package tmr_pkg;
  localparam int NCH    = 3;
  localparam int CNT_W  = 32;
  localparam int NBYTE  = CNT_W / 8;
  localparam int SHW    = 4 * NCH;          // shared word width
  localparam int DIRB   = 3 * NCH;          // first direction bit
  localparam logic [31:0] REV_ID = 32'h0001_0801;

  typedef enum logic [2:0] {
    KIND_NONE,
    KIND_CHAN,
    KIND_CTRL,
    KIND_STAT,
    KIND_MASK,
    KIND_REV
  } regKind_e;

  typedef struct packed {
    regKind_e    kind;
    logic [1:0]  chan;
    logic [1:0]  field;
    logic [1:0]  byteIdx;
    logic        wr;
  } busStrobe_t;
endpackage

// File: rtl/tmr_busdecode.sv
module tmr_busdecode
  import tmr_pkg::*;
#(
  parameter int CHANS = NCH
) (
  input  logic [5:0]  busAddr,
  input  logic        busWrEn,
  output busStrobe_t  strobe
);
  localparam logic [1:0] LAST_CH = 2'(CHANS - 1);

  always_comb begin
    strobe.chan    = busAddr[5:4];
    strobe.field   = busAddr[3:2];
    strobe.byteIdx = busAddr[1:0];
    strobe.wr      = busWrEn;
    if (busAddr[5:4] <= LAST_CH) begin
      strobe.kind = KIND_CHAN;
    end else begin
      unique case (busAddr[3:2])
        2'd0:    strobe.kind = KIND_CTRL;
        2'd1:    strobe.kind = KIND_STAT;
        2'd2:    strobe.kind = KIND_MASK;
        default: strobe.kind = KIND_REV;
      endcase
    end
  end
endmodule

// File: rtl/tmr_channel.sv
module tmr_channel #(
  parameter  int CNT_W = 32,
  localparam int NB    = CNT_W / 8
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             runEn,
  input  logic             slowSel,
  input  logic             countUp,
  input  logic             zeroIrqEn,
  input  logic             slowTick,
  input  logic [1:0]       wrField,
  input  logic [NB-1:0]    wrBytes,
  input  logic [7:0]       wrData,
  output logic [CNT_W-1:0] cntQ,
  output logic [CNT_W-1:0] relQ,
  output logic [CNT_W-1:0] m1Q,
  output logic [CNT_W-1:0] m2Q,
  output logic             hitM1,
  output logic             hitM2,
  output logic             hitOvf
);
  logic [CNT_W-1:0] cfgQ [1:3];
  logic [CNT_W-1:0] nextCnt;
  logic             tickOk, stepping, atZero, cntWr;

  function automatic logic [CNT_W-1:0] mergeBytes(
    input logic [CNT_W-1:0] old, input logic [NB-1:0] sel, input logic [7:0] d);
    logic [CNT_W-1:0] r;
    r = old;
    for (int b = 0; b < NB; b++) begin
      if (sel[b]) r[b*8 +: 8] = d;
    end
    return r;
  endfunction

  assign tickOk   = runEn & (slowSel ? slowTick : 1'b1);
  assign cntWr    = (wrField == 2'd0) && (|wrBytes);
  assign stepping = tickOk & ~cntWr;
  assign atZero   = (cntQ == '0);
  assign nextCnt  = atZero ? relQ : (countUp ? cntQ + 1'b1 : cntQ - 1'b1);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)         cntQ <= '0;
    else if (cntWr)    cntQ <= mergeBytes(cntQ, wrBytes, wrData);
    else if (stepping) cntQ <= nextCnt;
  end

  for (genvar f = 1; f <= 3; f++) begin : g_cfg
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) cfgQ[f] <= '0;
      else if (wrField == 2'(f) && (|wrBytes))
        cfgQ[f] <= mergeBytes(cfgQ[f], wrBytes, wrData);
    end
  end

  assign relQ   = cfgQ[1];
  assign m1Q    = cfgQ[2];
  assign m2Q    = cfgQ[3];
  assign hitM1  = stepping && (nextCnt == m1Q);
  assign hitM2  = stepping && (nextCnt == m2Q);
  assign hitOvf = stepping && atZero && zeroIrqEn;
endmodule

// File: rtl/tmr_datapath.sv
module tmr_datapath
  import tmr_pkg::*;
(
  input  logic                      clk,
  input  logic                      rstN,
  input  busStrobe_t                strobe,
  input  logic [7:0]                wrData,
  input  logic                      slowTick,
  output logic [7:0]                rdData,
  output logic                      irq,
  output logic [SHW-1:0]            ctrlQ,
  output logic [SHW-1:0]            statQ,
  output logic [SHW-1:0]            maskQ,
  output logic [NCH-1:0][CNT_W-1:0] cntAll,
  output logic [NCH-1:0][CNT_W-1:0] relAll
);
  logic [NCH-1:0][CNT_W-1:0] m1All, m2All;
  logic [NCH-1:0]            hitM1, hitM2, hitOvf;
  logic [SHW-1:0]            statSet, statClr;

  function automatic logic [SHW-1:0] putByte(
    input logic [SHW-1:0] old, input logic [1:0] idx, input logic [7:0] d);
    logic [31:0] t;
    t = 32'(old);
    t[idx*8 +: 8] = d;
    return t[SHW-1:0];
  endfunction

  for (genvar i = 0; i < NCH; i++) begin : g_ch
    logic [NBYTE-1:0] wrBytes;
    assign wrBytes = (strobe.wr && strobe.kind == KIND_CHAN && strobe.chan == 2'(i))
                     ? NBYTE'(1) << strobe.byteIdx : '0;
    tmr_channel #(.CNT_W(CNT_W)) u_ch (
      .clk(clk), .rstN(rstN),
      .runEn(ctrlQ[3*i]), .slowSel(ctrlQ[3*i+1]),
      .countUp(ctrlQ[DIRB+i]), .zeroIrqEn(ctrlQ[3*i+2]),
      .slowTick(slowTick),
      .wrField(strobe.field), .wrBytes(wrBytes), .wrData(wrData),
      .cntQ(cntAll[i]), .relQ(relAll[i]), .m1Q(m1All[i]), .m2Q(m2All[i]),
      .hitM1(hitM1[i]), .hitM2(hitM2[i]), .hitOvf(hitOvf[i])
    );
    assign statSet[3*i]   = hitM1[i];
    assign statSet[3*i+1] = hitM2[i];
    assign statSet[3*i+2] = hitOvf[i];
  end
  assign statSet[SHW-1:DIRB] = '0;

  always_comb begin
    logic [31:0] wide;
    wide    = 32'(wrData) << {strobe.byteIdx, 3'b000};
    statClr = (strobe.wr && strobe.kind == KIND_STAT) ? wide[SHW-1:0] : '0;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      ctrlQ <= '0;
      statQ <= '0;
      maskQ <= '0;
    end else begin
      statQ <= (statQ & ~statClr) | statSet;
      if (strobe.wr && strobe.kind == KIND_CTRL)
        ctrlQ <= putByte(ctrlQ, strobe.byteIdx, wrData);
      if (strobe.wr && strobe.kind == KIND_MASK)
        maskQ <= putByte(maskQ, strobe.byteIdx, wrData);
    end
  end

  always_comb begin
    logic [31:0] word;
    word = '0;
    unique case (strobe.kind)
      KIND_CHAN: begin
        for (int i = 0; i < NCH; i++) begin
          if (strobe.chan == 2'(i)) begin
            unique case (strobe.field)
              2'd0:    word = cntAll[i];
              2'd1:    word = relAll[i];
              2'd2:    word = m1All[i];
              default: word = m2All[i];
            endcase
          end
        end
      end
      KIND_CTRL: word = 32'(ctrlQ);
      KIND_STAT: word = 32'(statQ);
      KIND_MASK: word = 32'(maskQ);
      KIND_REV:  word = REV_ID;
      default:   word = '0;
    endcase
    rdData = word[{strobe.byteIdx, 3'b000} +: 8];
  end

  assign irq = |statQ;
endmodule

// File: rtl/triple_interval_timer.sv
module triple_interval_timer
  import tmr_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic [5:0] busAddr,
  input  logic       busWrEn,
  input  logic [7:0] busWrData,
  output logic [7:0] busRdData,
  input  logic       slowTick,
  output logic       irq
);
  busStrobe_t                strobe;
  logic [SHW-1:0]            ctrlQ, statQ, maskQ;
  logic [NCH-1:0][CNT_W-1:0] cntAll, relAll;

  tmr_busdecode #(.CHANS(NCH)) u_dec (
    .busAddr(busAddr), .busWrEn(busWrEn), .strobe(strobe)
  );

  tmr_datapath u_dp (
    .clk(clk), .rstN(rstN), .strobe(strobe), .wrData(busWrData),
    .slowTick(slowTick), .rdData(busRdData), .irq(irq),
    .ctrlQ(ctrlQ), .statQ(statQ), .maskQ(maskQ),
    .cntAll(cntAll), .relAll(relAll)
  );
endmodule

// File: rtl/tmr_checker.sv
module tmr_checker
  import tmr_pkg::*;
(
  input logic                      clk,
  input logic                      rstN,
  input logic [5:0]                busAddr,
  input logic                      busWrEn,
  input logic [7:0]                busRdData,
  input logic                      irq,
  input logic [SHW-1:0]            ctrlQ,
  input logic [SHW-1:0]            statQ,
  input logic [NCH-1:0][CNT_W-1:0] cntAll,
  input logic [NCH-1:0][CNT_W-1:0] relAll
);
  logic statWrite;
  assign statWrite = busWrEn && (busAddr == 6'h34 || busAddr == 6'h35);

  for (genvar i = 0; i < NCH; i++) begin : g_ch
    logic chanWr, cntWr;
    assign chanWr = busWrEn && busAddr[5:4] == 2'(i);
    assign cntWr  = chanWr && busAddr[3:2] == 2'd0;

    assert_hold_off_R12: assert property (@(posedge clk) disable iff (!rstN)
      (!ctrlQ[3*i] && !cntWr) |=> $stable(cntAll[i]));

    assert_down_step_R3: assert property (@(posedge clk) disable iff (!rstN)
      (ctrlQ[3*i] && !ctrlQ[3*i+1] && !ctrlQ[DIRB+i] && cntAll[i] != '0 && !cntWr)
      |=> cntAll[i] == $past(cntAll[i]) - 1'b1);

    assert_zero_reload_R6: assert property (@(posedge clk) disable iff (!rstN)
      (ctrlQ[3*i] && !ctrlQ[3*i+1] && cntAll[i] == '0 && !chanWr)
      |=> cntAll[i] == $past(relAll[i]));

    assert_ovf_gated_R8: assert property (@(posedge clk) disable iff (!rstN)
      $rose(statQ[3*i+2]) |-> $past(ctrlQ[3*i+2]));
  end

  assert_irq_drop_R9: assert property (@(posedge clk) disable iff (!rstN)
    $fell(irq) |-> $past(statWrite));

  assert_rev_byte_R11: assert property (@(posedge clk) disable iff (!rstN)
    (busAddr == 6'h3C) |-> busRdData == 8'h01);
endmodule

bind triple_interval_timer tmr_checker u_chk (
  .clk(clk), .rstN(rstN), .busAddr(busAddr), .busWrEn(busWrEn),
  .busRdData(busRdData), .irq(irq), .ctrlQ(ctrlQ), .statQ(statQ),
  .cntAll(cntAll), .relAll(relAll)
);

// File: tb/triple_interval_timer_test.sv
module triple_interval_timer_test;
  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic [5:0] busAddr = '0;
  logic       busWrEn = 1'b0;
  logic [7:0] busWrData = '0;
  logic [7:0] busRdData;
  logic       slowTick = 1'b0;
  logic       irq;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  triple_interval_timer uut (
    .clk(clk), .rstN(rstN), .busAddr(busAddr), .busWrEn(busWrEn),
    .busWrData(busWrData), .busRdData(busRdData), .slowTick(slowTick), .irq(irq)
  );

  // {addr, write byte, expected read-back}
  localparam int NV = 16;
  localparam logic [23:0] VEC [NV] = '{
    24'h04AAAA, 24'h075555, 24'h181212, 24'h2F9C9C,
    24'h31FF0F, 24'h310000, 24'h32FF00, 24'h33FF00,
    24'h38FFFF, 24'h39FF0F, 24'h3A7700, 24'h3C1201,
    24'h3D0008, 24'h3E0001, 24'h3F5500, 24'h35FF00
  };

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: got 0x%08h expected 0x%08h", tag, act, exp);
    end
  endtask

  task automatic step(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wr8(input logic [5:0] a, input logic [7:0] d);
    busAddr = a; busWrData = d; busWrEn = 1'b1;
    @(negedge clk);
    busWrEn = 1'b0;
  endtask

  task automatic wr32(input logic [5:0] a, input logic [31:0] d);
    for (int k = 0; k < 4; k++) wr8(a + 6'(k), d[k*8 +: 8]);
  endtask

  task automatic rd8(input logic [5:0] a, output logic [7:0] v);
    busAddr = a; #1; v = busRdData;
  endtask

  task automatic rd32(input logic [5:0] a, output logic [31:0] v);
    for (int k = 0; k < 4; k++) begin
      logic [7:0] b;
      rd8(a + 6'(k), b);
      v[k*8 +: 8] = b;
    end
  endtask

  task automatic tick();
    slowTick = 1'b1;
    @(negedge clk);
    slowTick = 1'b0;
  endtask

  task automatic summary();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog: got 0x%08h expected 0x%08h", 0, 1);
      summary();
      $finish;
    end
  end

  initial begin
    logic [31:0] w;
    logic [7:0]  b;

    // R1 reset state
    step(3);
    rd32(6'h00, w); check("R1 counter", w, 0);
    rd32(6'h24, w); check("R1 reload", w, 0);
    rd8(6'h30, b);  check("R1 control", 32'(b), 0);
    rd8(6'h34, b);  check("R1 status", 32'(b), 0);
    check("R1 irq", 32'(irq), 0);
    rstN = 1'b1;
    step(1);

    // table of byte writes and read-backs: R2 R10 R11
    for (int v = 0; v < NV; v++) begin
      wr8(VEC[v][23:16], VEC[v][15:8]);
      rd8(VEC[v][23:16], b);
      check($sformatf("R2 R10 R11 vector %0d", v), 32'(b), 32'(VEC[v][7:0]));
    end

    // R2 byte order
    wr32(6'h14, 32'h11223344);
    rd8(6'h14, b); check("R2 low byte", 32'(b), 32'h44);
    rd8(6'h17, b); check("R2 high byte", 32'(b), 32'h11);

    // R3 down count on system clock, R12 hold when disabled
    wr32(6'h00, 32'd10);
    wr8(6'h30, 8'h01);
    rd32(6'h00, w); check("R3 start", w, 10);
    step(3);
    rd32(6'h00, w); check("R3 three steps", w, 7);
    wr8(6'h30, 8'h00);
    rd32(6'h00, w); check("R3 last step", w, 6);
    step(2);
    rd32(6'h00, w); check("R12 disabled hold", w, 6);

    // R6 R7 R8 R10 reload, compare flags, overflow flag
    wr32(6'h00, 32'd2);
    wr32(6'h04, 32'h100);
    wr32(6'h08, 32'd1);
    wr32(6'h0C, 32'hFF);
    wr8(6'h30, 8'h05);
    step(1);
    rd8(6'h34, b); check("R7 compare A", 32'(b), 32'h01);
    step(2);
    rd32(6'h00, w); check("R6 reload down", w, 32'h100);
    rd8(6'h34, b);  check("R8 overflow set", 32'(b), 32'h05);
    check("R10 irq with mask set", 32'(irq), 1);
    step(1);
    rd8(6'h34, b); check("R7 compare B", 32'(b), 32'h07);
    wr8(6'h30, 8'h00);

    // R9 write-one-to-clear
    wr8(6'h34, 8'h02);
    rd8(6'h34, b); check("R9 partial clear", 32'(b), 32'h05);
    check("R10 irq still high", 32'(irq), 1);
    wr8(6'h34, 8'h05);
    rd8(6'h34, b); check("R9 full clear", 32'(b), 32'h00);
    check("R10 irq low", 32'(irq), 0);

    // R8 overflow gated off on timer 1
    wr32(6'h10, 32'd1);
    wr32(6'h14, 32'd5);
    wr32(6'h18, 32'hFFFFFFFF);
    wr32(6'h1C, 32'hFFFFFFFF);
    wr8(6'h30, 8'h08);
    step(2);
    rd32(6'h10, w); check("R6 timer 1 reload", w, 5);
    rd8(6'h34, b);  check("R8 overflow gated", 32'(b), 0);
    check("R8 irq low", 32'(irq), 0);
    wr8(6'h30, 8'h00);

    // R4 R5 slow tick, up count, wrap, reload on timer 2
    wr32(6'h20, 32'hFFFFFFFE);
    wr32(6'h24, 32'h42);
    wr32(6'h28, 32'hFFFFFFFF);
    wr32(6'h2C, 32'h43);
    wr8(6'h31, 8'h08);
    wr8(6'h30, 8'hC0);
    step(3);
    rd32(6'h20, w); check("R4 no tick hold", w, 32'hFFFFFFFE);
    tick();
    rd32(6'h20, w); check("R5 up step", w, 32'hFFFFFFFF);
    rd8(6'h34, b);  check("R7 timer 2 compare A", 32'(b), 32'h40);
    step(2);
    rd32(6'h20, w); check("R4 hold between ticks", w, 32'hFFFFFFFF);
    tick();
    rd32(6'h20, w); check("R5 wrap to zero", w, 0);
    tick();
    rd32(6'h20, w); check("R6 reload up", w, 32'h42);
    rd8(6'h35, b);  check("R8 timer 2 overflow gated", 32'(b), 0);
    tick();
    rd8(6'h34, b);  check("R7 timer 2 compare B", 32'(b), 32'hC0);
    wr8(6'h30, 8'h00);
    wr8(6'h31, 8'h00);
    wr8(6'h34, 8'hC0);

    // R9 hardware set wins over same-clock clear
    wr32(6'h00, 32'd5);
    wr32(6'h08, 32'd3);
    wr32(6'h0C, 32'hFFFFFFFF);
    wr8(6'h30, 8'h01);
    step(1);
    wr8(6'h34, 8'h01);
    rd8(6'h34, b); check("R9 set wins", 32'(b), 32'h01);
    wr8(6'h34, 8'h01);
    rd8(6'h34, b); check("R9 clear after", 32'(b), 32'h00);

    // R12 counter write beats count event
    wr8(6'h00, 8'h80);
    rd32(6'h00, w); check("R12 write priority", w, 32'h80);
    step(1);
    rd32(6'h00, w); check("R3 step after write", w, 32'h7F);
    wr8(6'h30, 8'h00);

    // R1 reset mid-run
    rstN = 1'b0;
    rd32(6'h20, w); check("R1 reset counter", w, 0);
    rd8(6'h38, b);  check("R1 reset mask", 32'(b), 0);
    check("R1 reset irq", 32'(irq), 0);
    step(1);
    rstN = 1'b1;

    done = 1'b1;
    summary();
    $finish;
  end
endmodule